// File: doc/BRIEF.md
# Multi-Fan Tachometer Speed Sampler

This block measures the rotation period of several fans in turn, one fan at a time, without software help. While a fan is under measurement its drive line is taken away from its PWM signal and held high, so the fan runs at full speed. The block then waits a fixed settling time. After that it times the interval from the first to the third rising edge on that fan's tachometer line. At the end the drive goes back to the PWM signal. The result goes into a per-fan entry of a status table. If the pulse group does not finish in time, the entry gets a fault mark in place of a reading. Fans that are not being measured always follow their own PWM signal.

All durations are counted in ticks of a slow time base. The settling time, the limit on the pulse group and the minimum gap between two measurements are parameters. A host reads the period counts and flags from the outputs and turns a period into a speed itself. A one-cycle strobe carrying the fan index and the count announces each new reading.

Top module: `fan_tach_scanner`

## Requirements
- R1: After a synchronous reset, every drive line follows its PWM input (registered, one cycle late), all period entries are zero, all valid and fault flags are low, and fan 0 is the first fan measured.
- R2: While a fan is being measured, its drive line is high whatever its PWM input is. Every other drive line equals its own PWM input as sampled one cycle earlier. At most one fan is forced at any time.
- R3: After the drive is forced, the block waits SETTLE_TICKS ticks before it accepts pulses. A tachometer pulse during that settling time has no effect on the stored period.
- R4: Only rising edges on the tachometer line of the fan being measured count as pulses. Pulses on the other fans' lines have no effect on the measurement.
- R5: On the third counted pulse, the fan's period entry gets the number of ticks between the first and the third pulse. Its valid flag is set, its fault flag is cleared, and for exactly one cycle res_valid is high with res_idx and res_period equal to the fan index and that count.
- R6: If the third pulse has not arrived when TIMEOUT_TICKS ticks have passed since the settling time ended, the fan's fault flag is set and its valid flag is cleared. Its period entry keeps its old value, no strobe is given, and a late pulse is ignored.
- R7: After each reading or fault, the drive of the next fan is forced exactly HOLDOFF_TICKS ticks later.
- R8: Fans are visited in the order 0, 1, …, NUM_FANS-1, and after the last fan the order starts again at 0.
- R9: When a measurement ends, by a reading or by a fault, the measured fan's drive line returns to following its PWM input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe |
| tach | input | NUM_FANS | Raw tachometer lines, asynchronous |
| pwm | input | NUM_FANS | Per-fan PWM drive requests |
| fan_drive | output | NUM_FANS | Registered drive lines to the fans |
| period_flat | output | NUM_FANS*CNT_W | Per-fan period counts, fan i at bits i*CNT_W upward |
| valid_flags | output | NUM_FANS | Per-fan reading-present flags |
| fault_flags | output | NUM_FANS | Per-fan abnormal-result flags |
| res_valid | output | 1 | One-cycle strobe for a new reading |
| res_idx | output | IDX_W | Fan index of the new reading |
| res_period | output | CNT_W | Tick count of the new reading |

## Verification
The bench goes after the edges of the timing window. A group that ends one tick before the limit must give a reading; a design whose compare is off by one would report a fault there instead. A group that needs exactly the limit must fault, and a pulse that comes late must not then be accepted. The bench sends a pulse during the settling time and pulses on fans that are not selected; a design that counts either of these stores a shorter period. It counts ticks between each result and the next forced drive, so a hold-off that is one tick short or one tick long shows up. The visit order is followed through a wrap back to fan 0. There a fresh reading must overwrite the older one, and a fault must clear an earlier valid flag.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_EDGE1  = 3'd2,
    ST_EDGE2  = 3'd3,
    ST_EDGE3  = 3'd4
  } scan_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/tach_rise_detect.sv
module tach_rise_detect #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] rise
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= raw[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise[g] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/tach_scan_fsm.sv
module tach_scan_fsm
  import fan_tach_pkg::*;
#(
  parameter int NUM_FANS      = 4,
  parameter int IDX_W         = 2,
  parameter int CNT_W         = 16,
  parameter int SETTLE_TICKS  = 2000,
  parameter int TIMEOUT_TICKS = 3000,
  parameter int HOLDOFF_TICKS = 4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             edge_sel,
  output logic [IDX_W-1:0] cur_idx,
  output logic             forcing,
  output logic             done,
  output logic             fail,
  output logic [IDX_W-1:0] end_idx,
  output logic [CNT_W-1:0] end_count
);
  localparam int TMAX = max3(SETTLE_TICKS, TIMEOUT_TICKS, HOLDOFF_TICKS);
  localparam int TW   = $clog2(TMAX + 1);

  scan_state_e      state;
  logic [TW-1:0]    tcnt;
  logic [CNT_W-1:0] pcnt;
  logic [IDX_W-1:0] next_idx;

  assign next_idx = (cur_idx == IDX_W'(NUM_FANS - 1)) ? '0 : cur_idx + 1'b1;
  assign forcing  = (state != ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HOLD;
      tcnt      <= '0;
      pcnt      <= '0;
      cur_idx   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      end_idx   <= '0;
      end_count <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state)
        ST_HOLD: begin
          if (tick) begin
            if (tcnt == TW'(HOLDOFF_TICKS - 1)) begin
              tcnt  <= '0;
              state <= ST_SETTLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (tick) begin
            if (tcnt == TW'(SETTLE_TICKS - 1)) begin
              tcnt  <= '0;
              pcnt  <= '0;
              state <= ST_EDGE1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: begin
          if (state == ST_EDGE3 && edge_sel) begin
            done      <= 1'b1;
            end_idx   <= cur_idx;
            end_count <= pcnt;
            cur_idx   <= next_idx;
            tcnt      <= '0;
            state     <= ST_HOLD;
          end else if (tick && tcnt == TW'(TIMEOUT_TICKS - 1)) begin
            fail    <= 1'b1;
            end_idx <= cur_idx;
            cur_idx <= next_idx;
            tcnt    <= '0;
            state   <= ST_HOLD;
          end else begin
            if (tick) tcnt <= tcnt + 1'b1;
            if (tick && state != ST_EDGE1) pcnt <= pcnt + 1'b1;
            if (edge_sel) begin
              if (state == ST_EDGE1) begin
                pcnt  <= '0;
                state <= ST_EDGE2;
              end else begin
                state <= ST_EDGE3;
              end
            end
          end
        end
      endcase
    end
  end

  // R8: the fan index only ever steps to its successor, wrapping at the end
  p_idx_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_idx) |-> (cur_idx == (($past(cur_idx) == IDX_W'(NUM_FANS - 1)) ? '0 : $past(cur_idx) + 1'b1)));

  // R6: the pulse-group timer never passes its limit
  p_window_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EDGE1 || state == ST_EDGE2 || state == ST_EDGE3) |-> (tcnt < TW'(TIMEOUT_TICKS)));

  // R7: every ending starts a fresh hold-off count
  p_end_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (state == ST_HOLD && tcnt == '0));
endmodule

// File: rtl/fan_tach_scanner.sv
module fan_tach_scanner #(
  parameter int NUM_FANS      = 4,
  parameter int CNT_W         = 16,
  parameter int SETTLE_TICKS  = 2000,
  parameter int TIMEOUT_TICKS = 3000,
  parameter int HOLDOFF_TICKS = 4000,
  parameter int IDX_W         = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic [NUM_FANS-1:0]       tach,
  input  logic [NUM_FANS-1:0]       pwm,
  output logic [NUM_FANS-1:0]       fan_drive,
  output logic [NUM_FANS*CNT_W-1:0] period_flat,
  output logic [NUM_FANS-1:0]       valid_flags,
  output logic [NUM_FANS-1:0]       fault_flags,
  output logic                      res_valid,
  output logic [IDX_W-1:0]          res_idx,
  output logic [CNT_W-1:0]          res_period
);
  logic [NUM_FANS-1:0] rise;
  logic [IDX_W-1:0]    cur_idx, end_idx;
  logic                forcing, done, fail;
  logic [CNT_W-1:0]    end_count;
  logic [CNT_W-1:0]    per_tab [NUM_FANS];

  tach_rise_detect #(.LANES(NUM_FANS)) u_rise (
    .clk (clk),
    .rst (rst),
    .raw (tach),
    .rise(rise)
  );

  tach_scan_fsm #(
    .NUM_FANS     (NUM_FANS),
    .IDX_W        (IDX_W),
    .CNT_W        (CNT_W),
    .SETTLE_TICKS (SETTLE_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .HOLDOFF_TICKS(HOLDOFF_TICKS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .edge_sel (rise[cur_idx]),
    .cur_idx  (cur_idx),
    .forcing  (forcing),
    .done     (done),
    .fail     (fail),
    .end_idx  (end_idx),
    .end_count(end_count)
  );

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
    always_ff @(posedge clk) begin
      if (rst) fan_drive[g] <= pwm[g];
      else     fan_drive[g] <= pwm[g] | (forcing && cur_idx == IDX_W'(g));
    end
    assign period_flat[g*CNT_W +: CNT_W] = per_tab[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FANS; i++) per_tab[i] <= '0;
      valid_flags <= '0;
      fault_flags <= '0;
      res_valid   <= 1'b0;
      res_idx     <= '0;
      res_period  <= '0;
    end else begin
      res_valid <= done;
      if (done) begin
        per_tab[end_idx]     <= end_count;
        valid_flags[end_idx] <= 1'b1;
        fault_flags[end_idx] <= 1'b0;
        res_idx              <= end_idx;
        res_period           <= end_count;
      end
      if (fail) begin
        valid_flags[end_idx] <= 1'b0;
        fault_flags[end_idx] <= 1'b1;
      end
    end
  end

  // R5: the strobe lasts one cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R5: the strobe agrees with the table entry it announces
  p_strobe_table_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (valid_flags[res_idx] && !fault_flags[res_idx] &&
                   period_flat[res_idx*CNT_W +: CNT_W] == res_period));

  // R6: a fan never shows a reading and a fault at once
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_flags & fault_flags) == '0);

  // R2: at most one drive line departs from its PWM request
  p_one_forced_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(fan_drive & ~$past(pwm)) <= 1);
endmodule

// File: tb/fan_tach_scanner_test.sv
module fan_tach_scanner_test;
  localparam int CLK_NS  = 10;
  localparam int N       = 4;
  localparam int CW      = 8;
  localparam int SETTLE  = 3;
  localparam int TMO     = 12;
  localparam int HOLD    = 5;
  localparam int IW      = 2;
  localparam int TDIV    = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick = 1'b0;
  logic [N-1:0]    tach = '0;
  logic [N-1:0]    pwm = '0;
  logic [N-1:0]    fan_drive;
  logic [N*CW-1:0] period_flat;
  logic [N-1:0]    valid_flags, fault_flags;
  logic            res_valid;
  logic [IW-1:0]   res_idx;
  logic [CW-1:0]   res_period;

  int errors = 0;
  int checks = 0;
  int tick_no = 0;
  int div = 0;
  int strobes = 0;
  int t_prev = 0;
  int last_idx = 0;
  int last_per = 0;

  fan_tach_scanner #(
    .NUM_FANS(N), .CNT_W(CW), .SETTLE_TICKS(SETTLE),
    .TIMEOUT_TICKS(TMO), .HOLDOFF_TICKS(HOLD)
  ) uut (
    .clk(clk), .rst(rst), .tick(tick), .tach(tach), .pwm(pwm),
    .fan_drive(fan_drive), .period_flat(period_flat),
    .valid_flags(valid_flags), .fault_flags(fault_flags),
    .res_valid(res_valid), .res_idx(res_idx), .res_period(res_period)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      div  <= 0;
      tick <= 1'b0;
    end else begin
      div  <= (div == TDIV - 1) ? 0 : div + 1;
      tick <= (div == TDIV - 1);
      if (tick) tick_no <= tick_no + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      strobes  = strobes + 1;
      last_idx = int'(res_idx);
      last_per = int'(res_period);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_until_tick(input int target);
    while (tick_no < target) @(negedge clk);
  endtask

  task automatic pulse(input int f);
    tach[f] = 1'b1;
    repeat (2) @(negedge clk);
    tach[f] = 1'b0;
    @(negedge clk);
  endtask

  function automatic int per_of(input int f);
    return int'(period_flat[f*CW +: CW]);
  endfunction

  // One measurement visit. ok=1: third pulse after d1+d2 ticks; ok=0: no third pulse in time
  task automatic visit(input int f, input int d1, input int d2, input bit ok);
    int t_rise, t_entry, s0, old_per;
    int other = (f + 1) % N;
    int side  = (f + 2) % N;
    old_per = per_of(f);
    while (fan_drive == '0) @(negedge clk);
    t_rise = tick_no;
    check("R8 visit order", int'(fan_drive), 1 << f);
    check("R7 hold-off ticks", t_rise - t_prev, HOLD);
    pwm[side] = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 unselected follows pwm", int'(fan_drive[side]), 1);
    check("R2 selected forced high", int'(fan_drive[f]), 1);
    pwm[side] = 1'b0;
    wait_until_tick(t_rise + 1);
    pulse(f);            // R3: falls inside the settling time
    t_entry = t_rise + SETTLE;
    wait_until_tick(t_entry);
    s0 = strobes;
    pulse(f);
    pulse(other);        // R4: other lane must not count
    wait_until_tick(t_entry + d1);
    pulse(f);
    pulse(other);
    if (ok) begin
      wait_until_tick(t_entry + d1 + d2);
      pulse(f);
      repeat (3) @(negedge clk);
      check("R5 strobe count", strobes - s0, 1);
      check("R5 strobe index", last_idx, f);
      check("R5 period count", last_per, d1 + d2);
      check("R5 table entry", per_of(f), d1 + d2);
      check("R5 valid flag", int'(valid_flags[f]), 1);
      check("R5 fault clear", int'(fault_flags[f]), 0);
      check("R9 drive released", int'(fan_drive[f]), 0);
    end else begin
      wait_until_tick(t_entry + TMO - 1);
      @(negedge clk);
      check("R6 not early fault", int'(fault_flags[f]), 0);
      check("R2 still forced", int'(fan_drive[f]), 1);
      wait_until_tick(t_entry + TMO);
      pulse(f);          // late third pulse
      repeat (2) @(negedge clk);
      check("R6 fault flag", int'(fault_flags[f]), 1);
      check("R6 valid cleared", int'(valid_flags[f]), 0);
      check("R6 period kept", per_of(f), old_per);
      check("R6 no strobe", strobes - s0, 0);
      check("R9 drive released", int'(fan_drive[f]), 0);
    end
    t_prev = tick_no;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    pwm = 4'b0101;
    repeat (3) @(negedge clk);
    check("R1 drive follows pwm in reset", int'(fan_drive), 5);
    pwm = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 drive after reset", int'(fan_drive), 0);
    check("R1 valid clear", int'(valid_flags), 0);
    check("R1 fault clear", int'(fault_flags), 0);
    check("R1 periods clear", int'(period_flat), 0);
    t_prev = 0;
    visit(0, 2, 3, 1'b1);
    visit(1, 1, 1, 1'b1);
    visit(2, 5, 6, 1'b1);        // R6 boundary: ends one tick before limit
    visit(3, 2, 0, 1'b0);
    visit(0, 4, 7, 1'b1);        // R8 wrap, R5 overwrite
    visit(1, 3, 9, 1'b0);        // R6 fault over earlier reading
    check("R5 fan0 kept", per_of(0), 11);
    check("R5 fan2 kept", per_of(2), 11);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule